// File: doc/BRIEF.md
# Switchable-rate DC-blocking high-pass filter

This block strips residual DC offset from a stream of signed 24-bit audio samples carried for two channels over one time-multiplexed input. Each accepted sample carries a channel tag. The block applies a first-order high-pass recursion, y[n] = x[n] - x[n-1] + y[n-1] - a*y[n-1], using the previous input and the previous output of that same channel. It returns the filtered sample one clock later, with the same tag and a valid strobe.

The leak factor a is always a power of two, so the product a*y is an arithmetic right shift and the block needs no multiplier. The exponent follows a 2-bit rate-mode input. Each doubling of the sample rate adds one to the exponent, so the corner frequency stays the same in hertz at 48, 96 and 192 kHz. The feedback state keeps 16 fractional bits below the sample LSB. The output is rounded back to 24 bits and clipped to the signed range. A bypass input routes samples through unfiltered while the filter state keeps tracking them, so leaving bypass causes no transient from stale state.

Top module: `dcblock_hpf`

## Requirements
- R1: Every cycle with `in_valid` high yields `out_valid` high on the next cycle, with `out_chan` equal to the accepted tag. A cycle with `in_valid` low yields `out_valid` low on the next cycle.
- R2: The state for each channel holds x[n-1] (24 bits) and y[n-1] with 16 fractional bits. The new state is y = ((x - x[n-1]) * 2^16) + y[n-1] - (y[n-1] >>> k), where >>> is an arithmetic shift (floor).
- R3: The exponent k is taken from `rate_mode`: code 2'b00 gives 11, 2'b01 gives 12 and 2'b10 gives 13. The code present in the cycle a sample is accepted applies to that sample.
- R4: Code 2'b11 is invalid. Samples accepted under it use the last exponent taken from a valid code (11 after reset). `mode_err` is high in the cycle after a cycle with code 2'b11 and low in the cycle after a cycle with a valid code.
- R5: Tag 0 is the left channel and tag 1 is the right channel. A sample updates and reads only the state of its own channel.
- R6: The output is (y + 2^15) >>> 16, which rounds half up to a 24-bit integer.
- R7: The output saturates to the range -8388608 to 8388607.
- R8: With `bypass` high, `out_data` equals the accepted `in_data`, with the same one-cycle timing. The channel state still updates exactly as in filtering mode.
- R9: A synchronous reset (`rst` high at a clock edge) clears all channel state and the output registers, clears `mode_err`, and sets the held exponent to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | 24 | Signed input sample |
| rate_mode | input | 2 | Sample-rate mode selecting the leak exponent |
| bypass | input | 1 | Pass samples through unfiltered |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 24 | Signed filtered sample |
| mode_err | output | 1 | Invalid rate mode seen on the previous cycle |

## Verification
The bench drives each sample on a falling edge, and the registered result is due on the next rising edge. Samples therefore go out on falling edges, and `out_valid`, `out_chan` and `out_data` are read one falling edge later. The same one-cycle spacing applies to `mode_err` after a change on `rate_mode`. The cycle that follows a sample with no new strobe is used to confirm that `out_valid` falls. Expected outputs come from a reference model in the bench that runs on 64-bit integers. The model picks its exponent from the mode present on the cycle the sample is driven. Reset is checked three falling edges after it is raised.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int unsigned DCB_DATA_W_DEF     = 24;
    localparam int unsigned DCB_FRAC_W_DEF     = 16;
    localparam int unsigned DCB_NUM_CH_DEF     = 2;
    localparam int unsigned DCB_BASE_SHIFT_DEF = 11;

    typedef enum logic [1:0] {
        RATE_SINGLE = 2'b00,
        RATE_DUAL   = 2'b01,
        RATE_QUAD   = 2'b10,
        RATE_BAD    = 2'b11
    } rate_e;

endpackage

// File: rtl/dcb_shift_sel.sv
module dcb_shift_sel
    import dcb_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = DCB_BASE_SHIFT_DEF,
    parameter int unsigned SH_W       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      rate_mode,
    output logic [SH_W-1:0] shift_eff,
    output logic            mode_err
);

    typedef struct packed {
        logic [SH_W-1:0] shift;
        logic            err;
    } sel_t;

    sel_t            sel_d, sel_q;
    logic            mode_bad;
    logic [SH_W-1:0] mode_shift;

    always_comb begin
        mode_bad   = (rate_e'(rate_mode) == RATE_BAD);
        mode_shift = SH_W'(BASE_SHIFT) + SH_W'(rate_mode);
        shift_eff  = mode_bad ? sel_q.shift : mode_shift;
        sel_d      = sel_q;
        sel_d.err  = mode_bad;
        if (!mode_bad) begin
            sel_d.shift = mode_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '{shift: SH_W'(BASE_SHIFT), err: 1'b0};
        end else begin
            sel_q <= sel_d;
        end
    end

    assign mode_err = sel_q.err;

endmodule

// File: rtl/dcb_chan_bank.sv
module dcb_chan_bank #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CH_W   = 1,
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ST_W   = 42
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic signed [DATA_W-1:0] wr_x,
    input  logic signed [ST_W-1:0]   wr_y,
    input  logic [CH_W-1:0]          rd_chan,
    output logic signed [DATA_W-1:0] rd_x,
    output logic signed [ST_W-1:0]   rd_y
);

    typedef struct packed {
        logic signed [ST_W-1:0]   y;
        logic signed [DATA_W-1:0] x;
    } ch_state_t;

    logic [NUM_CH-1:0][DATA_W-1:0] x_all;
    logic [NUM_CH-1:0][ST_W-1:0]   y_all;

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        ch_state_t ch_d, ch_q;

        always_comb begin
            ch_d = ch_q;
            if (wr_en && (wr_chan == CH_W'(g))) begin
                ch_d.x = wr_x;
                ch_d.y = wr_y;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_q <= '0;
            end else begin
                ch_q <= ch_d;
            end
        end

        assign x_all[g] = ch_q.x;
        assign y_all[g] = ch_q.y;
    end

    always_comb begin
        rd_x = '0;
        rd_y = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_chan == CH_W'(i)) begin
                rd_x = $signed(x_all[i]);
                rd_y = $signed(y_all[i]);
            end
        end
    end

endmodule

// File: rtl/dcb_hpf_core.sv
module dcb_hpf_core #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned ST_W   = 42,
    parameter int unsigned SH_W   = 4
) (
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] x_prev,
    input  logic signed [ST_W-1:0]   y_prev,
    input  logic [SH_W-1:0]          shift,
    output logic signed [ST_W-1:0]   y_next,
    output logic signed [DATA_W-1:0] y_out
);

    localparam int unsigned CW = ST_W + 2;

    localparam logic signed [CW-1:0] ST_MAX  = {{(CW-ST_W+1){1'b0}}, {(ST_W-1){1'b1}}};
    localparam logic signed [CW-1:0] ST_MIN  = ~ST_MAX;
    localparam logic signed [CW-1:0] OUT_MAX = {{(CW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [CW-1:0] OUT_MIN = ~OUT_MAX;
    localparam logic signed [CW-1:0] HALF    = CW'(1) << (FRAC_W-1);

    logic signed [CW-1:0] x_ext, xp_ext, diff, diff_sc;
    logic signed [CW-1:0] y_ext, leak, sum, ys_ext, rounded, q;

    always_comb begin
        x_ext   = {{(CW-DATA_W){x_in[DATA_W-1]}}, x_in};
        xp_ext  = {{(CW-DATA_W){x_prev[DATA_W-1]}}, x_prev};
        y_ext   = {{(CW-ST_W){y_prev[ST_W-1]}}, y_prev};
        diff    = x_ext - xp_ext;
        diff_sc = diff <<< FRAC_W;
        leak    = y_ext >>> shift;
        sum     = diff_sc + y_ext - leak;

        if (sum > ST_MAX) begin
            y_next = ST_MAX[ST_W-1:0];
        end else if (sum < ST_MIN) begin
            y_next = ST_MIN[ST_W-1:0];
        end else begin
            y_next = sum[ST_W-1:0];
        end

        ys_ext  = {{(CW-ST_W){y_next[ST_W-1]}}, y_next};
        rounded = ys_ext + HALF;
        q       = rounded >>> FRAC_W;

        if (q > OUT_MAX) begin
            y_out = OUT_MAX[DATA_W-1:0];
        end else if (q < OUT_MIN) begin
            y_out = OUT_MIN[DATA_W-1:0];
        end else begin
            y_out = q[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/dcblock_hpf.sv
module dcblock_hpf
    import dcb_pkg::*;
#(
    parameter int unsigned DATA_W     = DCB_DATA_W_DEF,
    parameter int unsigned FRAC_W     = DCB_FRAC_W_DEF,
    parameter int unsigned NUM_CH     = DCB_NUM_CH_DEF,
    parameter int unsigned BASE_SHIFT = DCB_BASE_SHIFT_DEF,
    localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ST_W      = DATA_W + FRAC_W + 2,
    localparam int unsigned SH_W      = $clog2(BASE_SHIFT + 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        rate_mode,
    input  logic              bypass,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              mode_err
);

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t                     o_d, o_q;
    logic [SH_W-1:0]          shift_eff;
    logic signed [DATA_W-1:0] x_prev;
    logic signed [ST_W-1:0]   y_prev, y_next;
    logic signed [DATA_W-1:0] y_out;

    dcb_shift_sel #(
        .BASE_SHIFT (BASE_SHIFT),
        .SH_W       (SH_W)
    ) u_shift_sel (
        .clk        (clk),
        .rst        (rst),
        .rate_mode  (rate_mode),
        .shift_eff  (shift_eff),
        .mode_err   (mode_err)
    );

    dcb_chan_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .ST_W   (ST_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_chan (in_chan),
        .wr_x    ($signed(in_data)),
        .wr_y    (y_next),
        .rd_chan (in_chan),
        .rd_x    (x_prev),
        .rd_y    (y_prev)
    );

    dcb_hpf_core #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .ST_W   (ST_W),
        .SH_W   (SH_W)
    ) u_core (
        .x_in   ($signed(in_data)),
        .x_prev (x_prev),
        .y_prev (y_prev),
        .shift  (shift_eff),
        .y_next (y_next),
        .y_out  (y_out)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = in_valid;
        if (in_valid) begin
            o_d.chan = in_chan;
            o_d.data = bypass ? in_data : y_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_chan  = o_q.chan;
    assign out_data  = o_q.data;

endmodule

// File: rtl/dcblock_hpf_chk.sv
module dcblock_hpf_chk #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned CH_W   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic [1:0]        rate_mode,
    input logic              bypass,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_chan,
    input logic [DATA_W-1:0] out_data,
    input logic              mode_err
);

    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_tag_carried: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_chan == $past(in_chan)));

    a_r4_err_raised: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'b11) |=> mode_err);

    a_r4_err_cleared: assert property (@(posedge clk) disable iff (rst)
        (rate_mode != 2'b11) |=> !mode_err);

    a_r8_bypass_passes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass) |=> (out_data == $past(in_data)));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_data == '0) && !mode_err));

endmodule

bind dcblock_hpf dcblock_hpf_chk #(
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .rate_mode (rate_mode),
    .bypass    (bypass),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data),
    .mode_err  (mode_err)
);

// File: tb/dcblock_hpf_bench.sv
module dcblock_hpf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_chan = 1'b0;
    logic [23:0] in_data = '0;
    logic [1:0]  rate_mode = 2'b00;
    logic        bypass = 1'b0;
    logic        out_valid, out_chan, mode_err;
    logic [23:0] out_data;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    longint m_y [2];
    longint m_x [2];
    int     m_sh = 11;

    always #2 clk = ~clk;

    dcblock_hpf u_dcblock_hpf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .rate_mode (rate_mode),
        .bypass    (bypass),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data),
        .mode_err  (mode_err)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_step(int ch, longint x, bit byp);
        longint yn, o;
        yn = ((x - m_x[ch]) <<< 16) + m_y[ch] - (m_y[ch] >>> m_sh);
        if (yn > (64'sd1 <<< 41) - 1) yn = (64'sd1 <<< 41) - 1;
        if (yn < -(64'sd1 <<< 41))    yn = -(64'sd1 <<< 41);
        m_y[ch] = yn;
        m_x[ch] = x;
        o = (yn + 32768) >>> 16;
        if (o > 8388607)  o = 8388607;
        if (o < -8388608) o = -8388608;
        return byp ? x : o;
    endfunction

    task automatic send(int ch, longint x, string req);
        longint exp;
        if (rate_mode != 2'b11) m_sh = 11 + int'(rate_mode);
        in_valid = 1'b1;
        in_chan  = ch[0];
        in_data  = x[23:0];
        exp      = model_step(ch, x, bypass);
        @(negedge clk);
        check(out_valid === 1'b1, req, "out_valid", longint'(out_valid), 1);
        check(out_chan === ch[0], req, "out_chan", longint'(out_chan), longint'(ch));
        check(longint'($signed(out_data)) == exp, req, "out_data",
              longint'($signed(out_data)), exp);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
        check(out_data === 24'd0, "R9", "out_data after reset", longint'($signed(out_data)), 0);
        check(mode_err === 1'b0, "R9", "mode_err after reset", longint'(mode_err), 0);
        rst = 1'b0;
        m_y = '{0, 0};
        m_x = '{0, 0};
        m_sh = 11;
    endtask

    task automatic test_first_and_idle();
        rate_mode = 2'b00;
        do_reset();
        send(0, 1000, "R2 first sample");
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid on idle", longint'(out_valid), 0);
        send(0, 1000, "R2 held input decays");
    endtask

    task automatic test_rates();
        for (int m = 0; m < 3; m++) begin
            rate_mode = m[1:0];
            do_reset();
            for (int i = 0; i < 6; i++) send(0, 4000000, "R3 rate exponent");
        end
    endtask

    task automatic test_channels();
        rate_mode = 2'b00;
        do_reset();
        send(0, 500000, "R5 left first");
        send(1, -300000, "R5 right unaffected by left");
        send(0, 500000, "R5 left own state");
        send(1, -300000, "R5 right own state");
    endtask

    task automatic test_bad_mode();
        rate_mode = 2'b11;
        do_reset();
        send(0, 2000000, "R4 bad mode after reset");
        send(0, 2000000, "R4 exponent 11 held from reset");
        check(mode_err === 1'b1, "R4", "mode_err raised", longint'(mode_err), 1);
        rate_mode = 2'b01;
        @(negedge clk);
        check(mode_err === 1'b0, "R4", "mode_err cleared", longint'(mode_err), 0);
        send(0, 2000000, "R4 dual exponent");
        rate_mode = 2'b11;
        send(0, 2000000, "R4 dual exponent held");
        send(0, 2000000, "R4 dual exponent held again");
        check(mode_err === 1'b1, "R4", "mode_err raised again", longint'(mode_err), 1);
    endtask

    task automatic test_rounding();
        rate_mode = 2'b10;
        do_reset();
        for (int i = 0; i < 8; i++) send(0, 3, "R6 positive rounding");
        for (int i = 0; i < 8; i++) send(1, -3, "R6 negative rounding");
    endtask

    task automatic test_saturation();
        rate_mode = 2'b00;
        do_reset();
        send(0, -8388608, "R7 negative full scale");
        send(0, 8388607, "R7 clip high");
        check(out_data === 24'h7FFFFF, "R7", "clip high literal",
              longint'($signed(out_data)), 8388607);
        send(0, -8388608, "R7 clip low");
        check(out_data === 24'h800000, "R7", "clip low literal",
              longint'($signed(out_data)), -8388608);
    endtask

    task automatic test_bypass();
        rate_mode = 2'b00;
        do_reset();
        bypass = 1'b1;
        send(0, 7777, "R8 bypass pass");
        send(0, 7777, "R8 bypass pass again");
        bypass = 1'b0;
        send(0, 7777, "R8 state tracked in bypass");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_first_and_idle();
        test_rates();
        test_channels();
        test_bad_mode();
        test_rounding();
        test_saturation();
        test_bypass();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule